// File: doc/BRIEF.md
# OTP Fuse Controller with Shadow Registers

This block sits between a simple register port and a small one-time-programmable fuse array. It keeps one shadow word for every fuse word. Software reads the shadow words at any time. Fuse contents reach a shadow only through an explicit reload. Fuse bits can only be set, never cleared. A separate set of lock rows records which words are permanently closed to programming.

Every fuse operation has two preconditions. The fuse macro must be powered, through a request bit and a delayed power-status bit, and the controller must be idle. Each operation keeps the controller busy for a fixed number of cycles. Three sticky per-word lock bitmaps guard the words: one forces reloads to zero, one blocks bus writes to the shadow, and one blocks programming. A global lock register can also block programming. Per-word error and disturbed bitmaps and a program-fail status bit report why an operation had no effect. The fuse model is behavioural and is cleared at reset.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset, all of the following read as zero: status, every bitmap register, every shadow word and every fuse word.
- R2: Status bit 5 (power on) takes the value of configuration bit 0 (address 0x000) exactly PWR_CYCLES clock edges after the edge that wrote it.
- R3: When idle, a write to control (0x004) starts an operation, and status bit 3 (busy) stays high for exactly OP_CYCLES cycles. A control write while busy is ignored, and control reads back the last accepted value.
- R4: A control value with bit 8 clear is a reload of word index bits[7:0]. When it completes, the shadow at 0x200+4N takes the fuse word, or zero if the word's shadow-read lock (0x094 bank) is set. The word's error and disturbed bits are cleared.
- R5: A control value with bit 8 set and bit 9 clear programs the word. The fuse word becomes the old value OR the write-data register (0x008). The shadow is not changed.
- R6: A bus write to shadow word N updates it immediately unless the word's shadow-write lock (0x07C bank) is set, in which case the write is ignored.
- R7: A program request is ignored, with no fuse change and program-fail cleared, when the word's program lock (0x064 bank) or bit 4 of the global lock (0x010) is set.
- R8: A control value with bits 8 and 9 set ORs write-data bits[15:0] into lock row N. The permanent-lock bitmap (0x04C bank) marks word N<32 when either bit of row N/8 at (2N)&15 is set, and word N>=32 from bit N&15 of row 4+(N-32)/16.
- R9: Status bit 4 (program fail) is set at completion of a program or lock request made with power off or with an out-of-range index (word >= 96, row >= 8). It is also set by a program request to a permanently locked word, which additionally sets that word's error bit (0x034 bank). Any other completed program or lock clears it.
- R10: A reload requested while power is off leaves the shadow unchanged and sets the word's disturbed bit (0x01C bank).
- R11: The sticky lock bitmaps and the global lock register only gain bits: writing 1 sets a bit, writing 0 has no effect.
- R12: Every per-word bitmap places word N at bit N&31 of the register at its base plus 4*(N>>5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the register at addr_i, combinational |

## Verification
Register reads are combinational, and a register write is visible right after the clock edge that samples it. The bench therefore drives each access at a falling edge and reads back 1 ns after the next falling edge. The power-status bit is due PWR_CYCLES edges after its request is written. The bench samples it once one edge early, to see the old value, and once on time, to see the new value. Operation results and the end of busy are due OP_CYCLES edges after the control write. The bench reads busy right after the start, again one edge before completion, and then at completion. It reads every other operation result only after the full OP_CYCLES wait.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_IGNORE, K_RELOAD, K_DISTURB, K_PROG, K_LOCK, K_FAIL, K_FAIL_LOCKED
  } op_kind_e;

  localparam logic [11:0] A_CFG    = 12'h000;
  localparam logic [11:0] A_CTRL   = 12'h004;
  localparam logic [11:0] A_WDATA  = 12'h008;
  localparam logic [11:0] A_STAT   = 12'h00C;
  localparam logic [11:0] A_GLOCK  = 12'h010;
  localparam logic [11:0] A_DIST   = 12'h01C;
  localparam logic [11:0] A_ERR    = 12'h034;
  localparam logic [11:0] A_PERM   = 12'h04C;
  localparam logic [11:0] A_SPLK   = 12'h064;
  localparam logic [11:0] A_SWLK   = 12'h07C;
  localparam logic [11:0] A_SRLK   = 12'h094;
  localparam logic [11:0] A_SHADOW = 12'h200;

  localparam int CTRL_PROG_BIT  = 8;
  localparam int CTRL_LOCK_BIT  = 9;
  localparam int GLOCK_PROG_BIT = 4;
  localparam int ST_BUSY = 3;
  localparam int ST_FAIL = 4;
  localparam int ST_PWR  = 5;

  // lower words take 2 bits per word (8 per row), upper ones 1 bit (16 per row)
  function automatic int lock_rows(input int words, input int lower);
    return lower / 8 + (words - lower + 15) / 16;
  endfunction
endpackage

// File: rtl/otp_power_seq.sv
module otp_power_seq #(
  parameter int PWR_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic on_o
);
  localparam int CW = $clog2(PWR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_o  <= 1'b0;
    end else if (req_i != on_o) begin
      if (cnt_q == CW'(PWR_CYCLES - 1)) begin
        cnt_q <= '0;
        on_o  <= req_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/otp_op_seq.sv
module otp_op_seq
  import otp_pkg::*;
#(
  parameter int OP_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  op_kind_e    kind_i,
  input  logic [7:0]  idx_i,
  input  logic [31:0] data_i,
  output logic        busy_o,
  output logic        done_o,
  output op_kind_e    kind_o,
  output logic [7:0]  idx_o,
  output logic [31:0] data_o
);
  localparam int CW = $clog2(OP_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_o <= K_NONE;
      idx_o  <= '0;
      data_o <= '0;
    end else if (start_i && cnt_q == '0) begin
      cnt_q  <= CW'(OP_CYCLES);
      kind_o <= kind_i;
      idx_o  <= idx_i;
      data_o <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
#(
  parameter int NUM_WORDS   = 96,
  parameter int LOWER_WORDS = 32,
  localparam int IDX_W      = $clog2(NUM_WORDS),
  localparam int LOCK_ROWS  = lock_rows(NUM_WORDS, LOWER_WORDS),
  localparam int ROW_W      = $clog2(LOCK_ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 prog_i,
  input  logic                 lock_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [31:0]          data_i,
  output logic [31:0]          rd_o,
  output logic [NUM_WORDS-1:0] perm_o
);
  logic [31:0] fuse_q [NUM_WORDS];
  logic [15:0] row_q  [LOCK_ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_WORDS; n++) fuse_q[n] <= '0;
      for (int r = 0; r < LOCK_ROWS; r++) row_q[r] <= '0;
    end else begin
      if (prog_i) fuse_q[idx_i] <= fuse_q[idx_i] | data_i;
      if (lock_i) row_q[idx_i[ROW_W-1:0]] <= row_q[idx_i[ROW_W-1:0]] | data_i[15:0];
    end
  end

  assign rd_o = (int'(idx_i) < NUM_WORDS) ? fuse_q[idx_i] : '0;

  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_perm
    if (n < LOWER_WORDS) begin : g_lo
      assign perm_o[n] = |row_q[n / 8][(2 * n) % 16 +: 2];
    end else begin : g_hi
      assign perm_o[n] = row_q[LOWER_WORDS / 8 + (n - LOWER_WORDS) / 16][n % 16];
    end
  end
endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_WORDS  = 96,
  parameter int OP_CYCLES  = 4,
  parameter int PWR_CYCLES = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int LOWER_WORDS = 32;
  localparam int IDX_W       = $clog2(NUM_WORDS);
  localparam int BANKS       = (NUM_WORDS + 31) / 32;
  localparam int VEC_W       = BANKS * 32;
  localparam int LOCK_ROWS   = lock_rows(NUM_WORDS, LOWER_WORDS);

  logic              cfg_q, fail_q;
  logic [31:0]       ctrl_q, wd_q, glock_q;
  logic [VEC_W-1:0]  dist_q, err_q, sp_q, sw_q, sr_q, perm_pad;
  logic [31:0]       shadow_q [NUM_WORDS];
  logic [NUM_WORDS-1:0] perm;

  logic        pwr_on, busy, op_done, start;
  op_kind_e    kind, op_kind;
  logic [7:0]  c_idx, op_idx;
  logic [31:0] op_data, fuse_rd;
  logic [IDX_W-1:0] oi;

  logic        wr, sh_hit;
  logic [11:0] sh_off;
  logic [IDX_W-1:0] sh_idx;

  assign wr     = req_i & we_i;
  assign sh_off = addr_i - A_SHADOW;
  assign sh_idx = sh_off[IDX_W+1:2];
  assign sh_hit = (addr_i >= A_SHADOW) && (int'(sh_off[11:2]) < NUM_WORDS) && (addr_i[1:0] == 2'b00);
  assign start  = wr && (addr_i == A_CTRL) && !busy;
  assign c_idx  = wdata_i[7:0];
  assign oi     = op_idx[IDX_W-1:0];

  always_comb begin
    perm_pad = '0;
    perm_pad[NUM_WORDS-1:0] = perm;
  end

  // operation outcome is decided at request time
  always_comb begin
    kind = K_NONE;
    if (!wdata_i[CTRL_PROG_BIT]) begin
      if (int'(c_idx) < NUM_WORDS) kind = pwr_on ? K_RELOAD : K_DISTURB;
    end else if (wdata_i[CTRL_LOCK_BIT]) begin
      if (int'(c_idx) >= LOCK_ROWS || !pwr_on) kind = K_FAIL;
      else if (glock_q[GLOCK_PROG_BIT])        kind = K_IGNORE;
      else                                     kind = K_LOCK;
    end else begin
      if (int'(c_idx) >= NUM_WORDS || !pwr_on)               kind = K_FAIL;
      else if (perm_pad[c_idx[IDX_W-1:0]])                   kind = K_FAIL_LOCKED;
      else if (sp_q[c_idx[IDX_W-1:0]] || glock_q[GLOCK_PROG_BIT]) kind = K_IGNORE;
      else                                                   kind = K_PROG;
    end
  end

  otp_power_seq #(.PWR_CYCLES(PWR_CYCLES)) u_pwr (
    .clk_i, .rst_ni, .req_i(cfg_q), .on_o(pwr_on)
  );

  otp_op_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .kind_i(kind), .idx_i(c_idx), .data_i(wd_q),
    .busy_o(busy), .done_o(op_done), .kind_o(op_kind), .idx_o(op_idx), .data_o(op_data)
  );

  otp_fuse_array #(.NUM_WORDS(NUM_WORDS), .LOWER_WORDS(LOWER_WORDS)) u_fuse (
    .clk_i, .rst_ni,
    .prog_i(op_done && op_kind == K_PROG),
    .lock_i(op_done && op_kind == K_LOCK),
    .idx_i(oi), .data_i(op_data), .rd_o(fuse_rd), .perm_o(perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= 1'b0; fail_q <= 1'b0;
      ctrl_q <= '0; wd_q <= '0; glock_q <= '0;
      dist_q <= '0; err_q <= '0; sp_q <= '0; sw_q <= '0; sr_q <= '0;
      for (int n = 0; n < NUM_WORDS; n++) shadow_q[n] <= '0;
    end else begin
      if (wr) begin
        if (addr_i == A_CFG)   cfg_q   <= wdata_i[0];
        if (addr_i == A_WDATA) wd_q    <= wdata_i;
        if (addr_i == A_GLOCK) glock_q <= glock_q | wdata_i;
        for (int b = 0; b < BANKS; b++) begin
          if (addr_i == A_SPLK + 12'(4 * b)) sp_q[b*32 +: 32] <= sp_q[b*32 +: 32] | wdata_i;
          if (addr_i == A_SWLK + 12'(4 * b)) sw_q[b*32 +: 32] <= sw_q[b*32 +: 32] | wdata_i;
          if (addr_i == A_SRLK + 12'(4 * b)) sr_q[b*32 +: 32] <= sr_q[b*32 +: 32] | wdata_i;
        end
        if (sh_hit && !sw_q[sh_idx]) shadow_q[sh_idx] <= wdata_i;
      end
      if (start) ctrl_q <= wdata_i;
      if (op_done) begin
        case (op_kind)
          K_RELOAD: begin
            shadow_q[oi] <= sr_q[oi] ? '0 : fuse_rd;
            dist_q[oi]   <= 1'b0;
            err_q[oi]    <= 1'b0;
          end
          K_DISTURB:                 dist_q[oi] <= 1'b1;
          K_PROG, K_LOCK, K_IGNORE:  fail_q <= 1'b0;
          K_FAIL:                    fail_q <= 1'b1;
          K_FAIL_LOCKED: begin
            fail_q     <= 1'b1;
            err_q[oi]  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CFG)        rdata_o[0] = cfg_q;
    else if (addr_i == A_CTRL)  rdata_o = ctrl_q;
    else if (addr_i == A_WDATA) rdata_o = wd_q;
    else if (addr_i == A_STAT) begin
      rdata_o[ST_BUSY] = busy;
      rdata_o[ST_FAIL] = fail_q;
      rdata_o[ST_PWR]  = pwr_on;
    end
    else if (addr_i == A_GLOCK) rdata_o = glock_q;
    else if (sh_hit)            rdata_o = shadow_q[sh_idx];
    for (int b = 0; b < BANKS; b++) begin
      if (addr_i == A_DIST + 12'(4 * b)) rdata_o = dist_q[b*32 +: 32];
      if (addr_i == A_ERR  + 12'(4 * b)) rdata_o = err_q[b*32 +: 32];
      if (addr_i == A_PERM + 12'(4 * b)) rdata_o = perm_pad[b*32 +: 32];
      if (addr_i == A_SPLK + 12'(4 * b)) rdata_o = sp_q[b*32 +: 32];
      if (addr_i == A_SWLK + 12'(4 * b)) rdata_o = sw_q[b*32 +: 32];
      if (addr_i == A_SRLK + 12'(4 * b)) rdata_o = sr_q[b*32 +: 32];
    end
  end
endmodule

// File: rtl/otp_shadow_ctrl_chk.sv
module otp_shadow_ctrl_chk #(
  parameter int OP_CYCLES = 4,
  parameter int VEC_W     = 96
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             pwr_on_i,
  input logic             cfg_i,
  input logic             fail_i,
  input logic [31:0]      glock_i,
  input logic [VEC_W-1:0] sp_i,
  input logic [VEC_W-1:0] sw_i,
  input logic [VEC_W-1:0] sr_i,
  input logic [VEC_W-1:0] perm_i
);
  int unsigned run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else         run_q <= busy_i ? run_q + 1 : 0;
  end

  AST_BUSY_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_i |-> run_q < OP_CYCLES); // R3
  AST_BUSY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_i) |-> run_q == OP_CYCLES); // R3
  AST_PWR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (pwr_on_i != $past(pwr_on_i)) |-> ($past(cfg_i) != $past(pwr_on_i))); // R2
  AST_FAIL_AT_OP: assert property (@(posedge clk_i) disable iff (!rst_ni) (fail_i != $past(fail_i)) |-> $past(busy_i)); // R9
  AST_STICKY_SP: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(sp_i) & ~sp_i) == '0); // R11
  AST_STICKY_SW: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(sw_i) & ~sw_i) == '0); // R11
  AST_STICKY_SR: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(sr_i) & ~sr_i) == '0); // R11
  AST_STICKY_GLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(glock_i) & ~glock_i) == '0); // R11
  AST_PERM_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(perm_i) & ~perm_i) == '0); // R8
endmodule

bind otp_shadow_ctrl otp_shadow_ctrl_chk #(.OP_CYCLES(OP_CYCLES), .VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .pwr_on_i(pwr_on), .cfg_i(cfg_q),
  .fail_i(fail_q), .glock_i(glock_q), .sp_i(sp_q), .sw_i(sw_q), .sr_i(sr_q), .perm_i(perm_pad)
);

// File: tb/sim_otp_shadow_ctrl.sv
`timescale 1ns/1ps
module sim_otp_shadow_ctrl;
  localparam int OP_CYCLES  = 4;
  localparam int PWR_CYCLES = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  otp_shadow_ctrl #(.NUM_WORDS(96), .OP_CYCLES(OP_CYCLES), .PWR_CYCLES(PWR_CYCLES)) u0 (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o
  );

  typedef struct packed {
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{12'h214, 32'hA5A5_0001, 12'h214, 32'hA5A5_0001, 4'd6},  // R6 shadow write
    '{12'h008, 32'h0000_1234, 12'h008, 32'h0000_1234, 4'd5},  // R5 write-data register
    '{12'h07C, 32'h0000_0020, 12'h07C, 32'h0000_0020, 4'd11}, // R11 set shadow-write lock word 5
    '{12'h214, 32'h0000_FFFF, 12'h214, 32'hA5A5_0001, 4'd6},  // R6 locked write ignored
    '{12'h07C, 32'h0000_0000, 12'h07C, 32'h0000_0020, 4'd11}, // R11 zero write keeps bit
    '{12'h080, 32'h0000_0001, 12'h080, 32'h0000_0001, 4'd12}, // R12 bank 1 bit 0 = word 32
    '{12'h280, 32'h0000_0007, 12'h280, 32'h0000_0000, 4'd12}, // R12 word 32 lock honoured
    '{12'h37C, 32'h0000_DEAD, 12'h37C, 32'h0000_DEAD, 4'd6},  // R6 last word
    '{12'h010, 32'h0000_0000, 12'h010, 32'h0000_0000, 4'd11}  // R11 global lock idle
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic [11:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(rq, rdata_o, exp);
  endtask

  task automatic do_op(input logic [31:0] ctrl, input logic [31:0] wd);
    bus_wr(12'h008, wd);
    bus_wr(12'h004, ctrl);
    repeat (OP_CYCLES) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1", 12'h00C, 32'h0);
    rd_chk("R1", 12'h200, 32'h0);
    rd_chk("R1", 12'h04C, 32'h0);
    rd_chk("R1", 12'h034, 32'h0);

    foreach (VECS[i]) begin
      bus_wr(VECS[i].wa, VECS[i].wd);
      rd_chk($sformatf("R%0d", VECS[i].rq), VECS[i].ra, VECS[i].ex);
    end

    // R2 power-up timing
    bus_wr(12'h000, 32'h1);
    repeat (PWR_CYCLES - 1) @(negedge clk);
    rd_chk("R2", 12'h00C, 32'h00);
    @(negedge clk);
    rd_chk("R2", 12'h00C, 32'h20);

    // R3 busy window, R5 program leaves shadow
    bus_wr(12'h008, 32'hF0);
    bus_wr(12'h004, 32'h10A);
    rd_chk("R3", 12'h00C, 32'h28);
    repeat (OP_CYCLES - 1) @(negedge clk);
    rd_chk("R3", 12'h00C, 32'h28);
    @(negedge clk);
    rd_chk("R3", 12'h00C, 32'h20);
    rd_chk("R5", 12'h228, 32'h0);

    // R4 reload, R5 bits OR together
    do_op(32'h10A, 32'h0F);
    do_op(32'h00A, 32'h0);
    rd_chk("R5", 12'h228, 32'hFF);

    // R3 control write while busy ignored
    bus_wr(12'h008, 32'h1);
    bus_wr(12'h004, 32'h00A);
    bus_wr(12'h004, 32'h10B);
    repeat (OP_CYCLES) @(negedge clk);
    rd_chk("R3", 12'h004, 32'h00A);
    do_op(32'h00B, 32'h0);
    rd_chk("R3", 12'h22C, 32'h0);

    // R4 shadow-read lock forces zero
    bus_wr(12'h094, 32'h400);
    do_op(32'h00A, 32'h0);
    rd_chk("R4", 12'h228, 32'h0);

    // R7 program sticky lock
    bus_wr(12'h064, 32'h1000);
    do_op(32'h10C, 32'h3);
    rd_chk("R7", 12'h00C, 32'h20);
    do_op(32'h00C, 32'h0);
    rd_chk("R7", 12'h230, 32'h0);

    // R8 upper word 40: row 4, bit 8
    do_op(32'h304, 32'h100);
    rd_chk("R8", 12'h050, 32'h100);
    do_op(32'h128, 32'h1);
    rd_chk("R9", 12'h00C, 32'h30);
    rd_chk("R9", 12'h038, 32'h100);

    // R8 lower word 3: row 0, bits 7:6
    do_op(32'h300, 32'hC0);
    rd_chk("R9", 12'h00C, 32'h20);
    rd_chk("R8", 12'h04C, 32'h8);

    // R9 index out of range
    do_op(32'h164, 32'h1);
    rd_chk("R9", 12'h00C, 32'h30);

    // R7 global program lock, R11 sticky
    bus_wr(12'h010, 32'h10);
    do_op(32'h10D, 32'h1);
    rd_chk("R7", 12'h00C, 32'h20);
    do_op(32'h00D, 32'h0);
    rd_chk("R7", 12'h234, 32'h0);
    bus_wr(12'h010, 32'h0);
    rd_chk("R11", 12'h010, 32'h10);

    // R2 power-down, R9 and R10 with power off
    bus_wr(12'h000, 32'h0);
    repeat (PWR_CYCLES) @(negedge clk);
    rd_chk("R2", 12'h00C, 32'h00);
    do_op(32'h10E, 32'h1);
    rd_chk("R9", 12'h00C, 32'h10);
    bus_wr(12'h23C, 32'h55);
    do_op(32'h00F, 32'h0);
    rd_chk("R10", 12'h01C, 32'h8000);
    rd_chk("R10", 12'h23C, 32'h55);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule